// File: doc/BRIEF.md
# AUX Channel Request Packer and Reply Unpacker

This block turns one AUX channel request into the exact bytes a transmitter sends. It also decodes the bytes that come back. The request is given as a 4-bit command, a 20-bit address, a byte length and up to 20 payload bytes, and a one-cycle strobe starts it. The block classifies the command and builds the 3- or 4-byte header. It appends the payload for write kinds and then packs the message into five 32-bit words. The first byte of each group of four sits in the most significant lane.

When the words are complete, a single-cycle done pulse marks them valid, together with the transmit byte count and an error flag. They stay unchanged until the next request strobe.

A reply is given as five 32-bit words and a received byte count, with its own strobe. One cycle later the block presents three results. The first is the reply code. The second is the returned length, which depends on the kind of the last accepted request. The third is the returned data bytes. A reply that cannot be decoded raises an error flag.

Top module: `aux_msg_codec`

## Requirements
- R1: Message byte 0 is {command[3:0], address[19:16]}, byte 1 is address[15:8] and byte 2 is address[7:0].
- R2: A request with nonzero length N carries byte 3 = N-1. A zero-length request is 3 bytes long, and everything from byte 3 upward is zero.
- R3: A write kind sends the header followed by payload bytes 0..N-1, so the transmit count is 4+N (3 when N=0). A read kind sends only the header, so the count is 4 (3 when N=0).
- R4: Message byte i is placed in word i/4 at bits [(3-(i%4))*8+7 : (3-(i%4))*8], and word w sits at bits [w*32+31 : w*32] of the flat word bus. Payload byte j is taken from bits [j*8+7 : j*8] of the payload input. Bytes past the transmit count, and payload input bytes past N, appear as zero.
- R5: A write with N>16, or a read with N+1>20, raises the request error. The transmit count is then 0 and all five words are zero.
- R6: Bit 2 of the command (the middle-of-transaction flag) is ignored for classification, although it is still sent in byte 0. The base codes 8, 0 and 2 are write kinds and 9 and 1 are read kinds. Every other base code raises the request error.
- R7: Request done is high for exactly one cycle, on the fifth clock edge after the edge that samples the request strobe. From then until the next request strobe, the words, the count and the error flag do not change.
- R8: Reply done is high for exactly the one cycle after the edge that samples the reply strobe. The reply code is bits 7:4 of received byte 0.
- R9: After a read of length N, the returned length is min(count, N+1)-1. Returned data byte j (bits [j*8+7 : j*8]) is received byte j+1 for j below that length and zero above it.
- R10: After a write of length N, a count of 1 returns length N. A count of 2 or more returns min(received byte 1, N). The returned data is all zero in both cases.
- R11: A received count of 0 or above 20 raises the reply error, and so does a reply whose last request was erroneous. The code, length and data are then zero.
- R12: While reset is asserted, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqStrobe | input | 1 | Starts packing of a request |
| reqCmd | input | 4 | Request command nibble |
| reqAddr | input | 20 | Request address |
| reqLen | input | 5 | Payload length in bytes |
| reqPayload | input | 160 | Payload bytes, byte j at bits j*8+7:j*8 |
| rplStrobe | input | 1 | Starts decoding of a reply |
| rplWords | input | 160 | Received words, word w at bits w*32+31:w*32 |
| rplCount | input | 5 | Number of received bytes |
| txWords | output | 160 | Packed message words |
| txCount | output | 5 | Bytes to transmit |
| reqDone | output | 1 | One-cycle pulse, words valid |
| reqErr | output | 1 | Request rejected |
| rplDone | output | 1 | One-cycle pulse, reply outputs valid |
| rplCode | output | 4 | Reply command nibble |
| rplLen | output | 5 | Returned byte count |
| rplData | output | 160 | Returned data bytes |
| rplErr | output | 1 | Reply rejected |

## Verification
A stale or misrouted word index shows up as a header or payload byte in the wrong lane or word. It is visible on the word bus at the done pulse, five cycles after the strobe. A wrong sequencer state shifts the done pulse or lets the words move after it, and this is caught on the next clock. A wrongly latched request kind or length stays hidden until the next reply. It then appears as a wrong returned length or data mask in the cycle after the reply strobe. To expose it, every request class is followed by replies whose counts fall below, at and above the expected size.

// File: rtl/aux_codec_pkg.sv
package aux_codec_pkg;
  localparam int AUX_WORDS  = 5;
  localparam int LANES      = 4;
  localparam int MSG_BYTES  = AUX_WORDS * LANES;
  localparam int HDR_BYTES  = 4;
  localparam int ADDR_BYTES = 3;
  localparam int CMD_W      = 4;
  localparam int ADDR_W     = 20;
  localparam int LEN_W      = $clog2(MSG_BYTES + 1);
  localparam int IDX_W      = $clog2(AUX_WORDS);
  localparam int BUS_W      = AUX_WORDS * 32;
  localparam logic [CMD_W-1:0] MOT_MASK = 4'b0100;

  typedef enum logic [1:0] {KIND_NONE, KIND_WRITE, KIND_READ} req_kind_t;

  typedef struct packed {
    logic             capture;
    logic             packWord;
    logic [IDX_W-1:0] wordIdx;
    logic             unpack;
  } ctl_strobe_t;

  function automatic req_kind_t classifyCmd(logic [CMD_W-1:0] cmd);
    logic [CMD_W-1:0] base;
    base = cmd & ~MOT_MASK;
    case (base)
      4'h8, 4'h0, 4'h2: return KIND_WRITE;
      4'h9, 4'h1:       return KIND_READ;
      default:          return KIND_NONE;
    endcase
  endfunction
endpackage

// File: rtl/aux_codec_ctrl.sv
module aux_codec_ctrl
  import aux_codec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqStrobe,
  input  logic        rplStrobe,
  output ctl_strobe_t strobes,
  output logic        reqDone
);
  typedef enum logic {S_IDLE, S_PACK} state_t;
  state_t           state;
  logic [IDX_W-1:0] idx;
  logic             lastWord;

  assign lastWord = (idx == IDX_W'(AUX_WORDS - 1));

  always_comb begin
    strobes.capture  = reqStrobe;
    strobes.packWord = (state == S_PACK) && !reqStrobe;
    strobes.wordIdx  = idx;
    strobes.unpack   = rplStrobe;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      idx     <= '0;
      reqDone <= 1'b0;
    end else begin
      reqDone <= strobes.packWord && lastWord;
      if (reqStrobe) begin
        state <= S_PACK;
        idx   <= '0;
      end else if (state == S_PACK) begin
        if (lastWord) begin
          state <= S_IDLE;
          idx   <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/aux_codec_datapath.sv
module aux_codec_datapath
  import aux_codec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctl_strobe_t          strobes,
  input  logic [CMD_W-1:0]     reqCmd,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [LEN_W-1:0]     reqLen,
  input  logic [MSG_BYTES*8-1:0] reqPayload,
  input  logic [BUS_W-1:0]     rplWords,
  input  logic [LEN_W-1:0]     rplCount,
  output logic [BUS_W-1:0]     txWords,
  output logic [LEN_W-1:0]     txCount,
  output logic                 reqErr,
  output logic                 rplDone,
  output logic [3:0]           rplCode,
  output logic [LEN_W-1:0]     rplLen,
  output logic [MSG_BYTES*8-1:0] rplData,
  output logic                 rplErr
);
  logic [7:0]       msgBuf    [MSG_BYTES];
  logic [7:0]       nextBytes [MSG_BYTES];
  wire  [31:0]      packedWord [AUX_WORDS];
  wire  [7:0]       rxByte    [MSG_BYTES];
  req_kind_t        newKind, kindQ;
  logic             newErr, lenNz;
  logic [LEN_W-1:0] newCount, lenQ;

  // request build
  always_comb begin
    newKind = classifyCmd(reqCmd);
    lenNz   = (reqLen != '0);
    case (newKind)
      KIND_WRITE: newErr = int'(reqLen) > (MSG_BYTES - HDR_BYTES);
      KIND_READ:  newErr = int'(reqLen) + 1 > MSG_BYTES;
      default:    newErr = 1'b1;
    endcase
    if (newErr)                   newCount = '0;
    else if (!lenNz)              newCount = LEN_W'(ADDR_BYTES);
    else if (newKind == KIND_WRITE) newCount = LEN_W'(HDR_BYTES) + reqLen;
    else                          newCount = LEN_W'(HDR_BYTES);
    for (int i = 0; i < MSG_BYTES; i++) nextBytes[i] = '0;
    if (!newErr) begin
      nextBytes[0] = {reqCmd, reqAddr[19:16]};
      nextBytes[1] = reqAddr[15:8];
      nextBytes[2] = reqAddr[7:0];
      if (lenNz) nextBytes[3] = 8'(reqLen) - 8'd1;
      if (newKind == KIND_WRITE) begin
        for (int j = 0; j < MSG_BYTES - HDR_BYTES; j++) begin
          if (j < int'(reqLen)) nextBytes[HDR_BYTES + j] = reqPayload[j*8 +: 8];
        end
      end
    end
  end

  // lane mapping: first byte of a group in the top lane
  for (genvar w = 0; w < AUX_WORDS; w++) begin : g_word
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign packedWord[w][(LANES-1-l)*8 +: 8] = msgBuf[w*LANES + l];
      assign rxByte[w*LANES + l] = rplWords[w*32 + (LANES-1-l)*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MSG_BYTES; i++) msgBuf[i] <= '0;
      kindQ   <= KIND_NONE;
      lenQ    <= '0;
      txCount <= '0;
      reqErr  <= 1'b0;
      txWords <= '0;
    end else if (strobes.capture) begin
      for (int i = 0; i < MSG_BYTES; i++) msgBuf[i] <= nextBytes[i];
      kindQ   <= newErr ? KIND_NONE : newKind;
      lenQ    <= reqLen;
      txCount <= newCount;
      reqErr  <= newErr;
      txWords <= '0;
    end else if (strobes.packWord) begin
      for (int w = 0; w < AUX_WORDS; w++) begin
        if (strobes.wordIdx == IDX_W'(w)) txWords[w*32 +: 32] <= packedWord[w];
      end
    end
  end

  // reply decode
  logic                 badRpl;
  logic [LEN_W:0]       readLim, effCnt;
  logic [LEN_W-1:0]     nextLen;
  logic [MSG_BYTES*8-1:0] nextData;

  always_comb begin
    badRpl   = (rplCount == '0) || (int'(rplCount) > MSG_BYTES) || (kindQ == KIND_NONE);
    readLim  = {1'b0, lenQ} + 1'b1;
    nextLen  = '0;
    nextData = '0;
    effCnt   = '0;
    if (!badRpl) begin
      if (kindQ == KIND_WRITE) begin
        if (rplCount >= LEN_W'(2)) begin
          nextLen = ({3'b0, rxByte[1]} > (LEN_W+3)'(lenQ)) ? lenQ : LEN_W'(rxByte[1]);
        end else begin
          nextLen = lenQ;
        end
      end else begin
        effCnt  = ({1'b0, rplCount} < readLim) ? {1'b0, rplCount} : readLim;
        nextLen = LEN_W'(effCnt - 1'b1);
        for (int j = 0; j < MSG_BYTES - 1; j++) begin
          if (j < int'(nextLen)) nextData[j*8 +: 8] = rxByte[j + 1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rplDone <= 1'b0;
      rplCode <= '0;
      rplLen  <= '0;
      rplData <= '0;
      rplErr  <= 1'b0;
    end else begin
      rplDone <= strobes.unpack;
      if (strobes.unpack) begin
        rplErr  <= badRpl;
        rplCode <= badRpl ? 4'h0 : rxByte[0][7:4];
        rplLen  <= nextLen;
        rplData <= nextData;
      end
    end
  end
endmodule

// File: rtl/aux_msg_codec.sv
module aux_msg_codec
  import aux_codec_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqStrobe,
  input  logic [CMD_W-1:0]       reqCmd,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [LEN_W-1:0]       reqLen,
  input  logic [MSG_BYTES*8-1:0] reqPayload,
  input  logic                   rplStrobe,
  input  logic [BUS_W-1:0]       rplWords,
  input  logic [LEN_W-1:0]       rplCount,
  output logic [BUS_W-1:0]       txWords,
  output logic [LEN_W-1:0]       txCount,
  output logic                   reqDone,
  output logic                   reqErr,
  output logic                   rplDone,
  output logic [3:0]             rplCode,
  output logic [LEN_W-1:0]       rplLen,
  output logic [MSG_BYTES*8-1:0] rplData,
  output logic                   rplErr
);
  ctl_strobe_t strobes;

  aux_codec_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqStrobe (reqStrobe),
    .rplStrobe (rplStrobe),
    .strobes   (strobes),
    .reqDone   (reqDone)
  );

  aux_codec_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .reqCmd     (reqCmd),
    .reqAddr    (reqAddr),
    .reqLen     (reqLen),
    .reqPayload (reqPayload),
    .rplWords   (rplWords),
    .rplCount   (rplCount),
    .txWords    (txWords),
    .txCount    (txCount),
    .reqErr     (reqErr),
    .rplDone    (rplDone),
    .rplCode    (rplCode),
    .rplLen     (rplLen),
    .rplData    (rplData),
    .rplErr     (rplErr)
  );
endmodule

// File: rtl/aux_msg_codec_checks.sv
module aux_msg_codec_checks
  import aux_codec_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   reqStrobe,
  input logic [CMD_W-1:0]       reqCmd,
  input logic [ADDR_W-1:0]      reqAddr,
  input logic [LEN_W-1:0]       reqLen,
  input logic [MSG_BYTES*8-1:0] reqPayload,
  input logic                   rplStrobe,
  input logic [BUS_W-1:0]       rplWords,
  input logic [LEN_W-1:0]       rplCount,
  input logic [BUS_W-1:0]       txWords,
  input logic [LEN_W-1:0]       txCount,
  input logic                   reqDone,
  input logic                   reqErr,
  input logic                   rplDone,
  input logic [3:0]             rplCode,
  input logic [LEN_W-1:0]       rplLen,
  input logic [MSG_BYTES*8-1:0] rplData,
  input logic                   rplErr
);
  logic held, armed;
  logic [IDX_W:0] sinceStrobe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      held        <= 1'b0;
      armed       <= 1'b0;
      sinceStrobe <= '0;
    end else begin
      if (reqStrobe) held <= 1'b0;
      else if (reqDone) held <= 1'b1;
      if (reqStrobe) begin
        armed       <= 1'b1;
        sinceStrobe <= '0;
      end else if (sinceStrobe != '1) begin
        sinceStrobe <= sinceStrobe + 1'b1;
      end
    end
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |=> !reqDone);

  p_done_window_r7: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |-> (armed && sinceStrobe == (IDX_W+1)'(AUX_WORDS)));

  p_hold_after_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((held || reqDone) && !reqStrobe) |=> ($stable(txWords) && $stable(txCount) && $stable(reqErr)));

  p_err_empty_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqDone && reqErr) |-> (txCount == '0 && txWords == '0));

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    int'(txCount) <= MSG_BYTES);

  p_rpl_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    rplStrobe |=> rplDone);

  p_rpl_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rplStrobe |=> !rplDone);

  p_rpl_err_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rplDone && rplErr) |-> (rplLen == '0 && rplCode == 4'h0 && rplData == '0));

  p_rpl_len_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    rplDone |-> int'(rplLen) < MSG_BYTES);
endmodule

bind aux_msg_codec aux_msg_codec_checks u_checks (.*);

// File: tb/aux_msg_codec_bench.sv
module aux_msg_codec_bench;
  import aux_codec_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqStrobe = 1'b0;
  logic [CMD_W-1:0] reqCmd = '0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [LEN_W-1:0] reqLen = '0;
  logic [MSG_BYTES*8-1:0] reqPayload = '0;
  logic rplStrobe = 1'b0;
  logic [BUS_W-1:0] rplWords = '0;
  logic [LEN_W-1:0] rplCount = '0;
  logic [BUS_W-1:0] txWords;
  logic [LEN_W-1:0] txCount;
  logic reqDone, reqErr, rplDone, rplErr;
  logic [3:0] rplCode;
  logic [LEN_W-1:0] rplLen;
  logic [MSG_BYTES*8-1:0] rplData;

  always #5 clk = ~clk;

  aux_msg_codec u_aux_msg_codec (.*);

  int nVec = 0;
  int nBad = 0;
  int lastKind = 0;
  int lastLen = 0;
  logic [7:0] rb [MSG_BYTES];

  task automatic chk(string what, logic [BUS_W-1:0] act, logic [BUS_W-1:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic doReq(string tag, logic [3:0] cmd, logic [19:0] addr, int len, int seed);
    logic [7:0] b [MSG_BYTES];
    logic [BUS_W-1:0] expW, heldW;
    logic [3:0] base;
    bit isW, isR, err;
    int cnt;
    base = cmd & 4'hB;
    isW = (base == 4'h8) || (base == 4'h0) || (base == 4'h2);
    isR = (base == 4'h9) || (base == 4'h1);
    err = !(isW || isR) || (isW && len > 16) || (isR && len > 19);
    for (int i = 0; i < MSG_BYTES; i++) b[i] = 8'h00;
    cnt = 0;
    if (!err) begin
      b[0] = {cmd, addr[19:16]};
      b[1] = addr[15:8];
      b[2] = addr[7:0];
      if (len > 0) b[3] = 8'(len - 1);
      if (isW) for (int j = 0; j < len; j++) b[4 + j] = 8'(seed + j * 37);
      cnt = isW ? (len > 0 ? 4 + len : 3) : (len > 0 ? 4 : 3);
    end
    expW = '0;
    for (int w = 0; w < AUX_WORDS; w++)
      for (int l = 0; l < 4; l++) expW[w*32 + (3-l)*8 +: 8] = b[w*4 + l];
    reqCmd = cmd;
    reqAddr = addr;
    reqLen = LEN_W'(len);
    for (int j = 0; j < MSG_BYTES; j++) reqPayload[j*8 +: 8] = 8'(seed + j * 37);
    reqStrobe = 1'b1;
    @(negedge clk);
    reqStrobe = 1'b0;
    for (int c = 1; c <= AUX_WORDS; c++) begin
      @(negedge clk);
      chk({tag, " R7 done timing"}, BUS_W'(reqDone), BUS_W'(c == AUX_WORDS));
    end
    chk({tag, " R1/R2/R4 words"}, txWords, expW);
    chk({tag, " R3 count"}, BUS_W'(txCount), BUS_W'(cnt));
    chk({tag, " R5/R6 error"}, BUS_W'(reqErr), BUS_W'(err));
    heldW = txWords;
    reqPayload = ~reqPayload;
    @(negedge clk);
    @(negedge clk);
    chk({tag, " R7 done low"}, BUS_W'(reqDone), '0);
    chk({tag, " R7 words held"}, txWords, heldW);
    lastKind = err ? 0 : (isW ? 1 : 2);
    lastLen = len;
  endtask

  task automatic doRpl(string tag, int count);
    bit bad;
    int eLen, eff;
    logic [3:0] eCode;
    logic [MSG_BYTES*8-1:0] eData;
    bad = (count == 0) || (count > MSG_BYTES) || (lastKind == 0);
    eCode = bad ? 4'h0 : rb[0][7:4];
    eLen = 0;
    eData = '0;
    if (!bad && lastKind == 1) begin
      if (count >= 2) eLen = (int'(rb[1]) > lastLen) ? lastLen : int'(rb[1]);
      else eLen = lastLen;
    end else if (!bad) begin
      eff = (count < lastLen + 1) ? count : lastLen + 1;
      eLen = eff - 1;
      for (int j = 0; j < eLen; j++) eData[j*8 +: 8] = rb[j + 1];
    end
    for (int i = 0; i < MSG_BYTES; i++) rplWords[(i/4)*32 + (3 - i%4)*8 +: 8] = rb[i];
    rplCount = LEN_W'(count);
    rplStrobe = 1'b1;
    @(negedge clk);
    rplStrobe = 1'b0;
    chk({tag, " R8 reply done"}, BUS_W'(rplDone), BUS_W'(1));
    chk({tag, " R8 reply code"}, BUS_W'(rplCode), BUS_W'(eCode));
    chk({tag, " R9/R10 reply length"}, BUS_W'(rplLen), BUS_W'(eLen));
    chk({tag, " R9/R10 reply data"}, rplData, eData);
    chk({tag, " R11 reply error"}, BUS_W'(rplErr), BUS_W'(bad));
    @(negedge clk);
    chk({tag, " R8 reply done low"}, BUS_W'(rplDone), '0);
  endtask

  task automatic fillReply(int seed);
    for (int i = 0; i < MSG_BYTES; i++) rb[i] = 8'(seed * 11 + i * 29);
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog R7 act=hung exp=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset words", txWords, '0);
    chk("R12 reset flags", BUS_W'({reqDone, reqErr, rplDone, rplErr}), '0);
    chk("R12 reset count", BUS_W'(txCount), '0);
    chk("R12 reset reply", BUS_W'({rplCode, rplLen}), '0);
    chk("R12 reset data", rplData, '0);
    rstN = 1'b1;
    @(negedge clk);

    // write kinds
    doReq("native write len3", 4'h8, 20'h12345, 3, 5);
    fillReply(1); rb[0] = 8'h00; doRpl("write ack only R10", 1);
    rb[1] = 8'd2; doRpl("short write R10", 2);
    rb[1] = 8'd9; doRpl("short write clamp R10", 2);
    rb[1] = 8'd1; doRpl("write count above 2 R10", 7);
    doReq("i2c write max R3", 4'h0, 20'hABCDE, 16, 9);
    doReq("status update mot R6", 4'h6, 20'h00F0F, 1, 3);
    doReq("write len0 R2", 4'h8, 20'h80001, 0, 1);
    doReq("write oversize R5", 4'h8, 20'h11111, 17, 2);
    fillReply(2); doRpl("reply after error R11", 4);

    // read kinds
    doReq("native read len4", 4'h9, 20'h00200, 4, 7);
    fillReply(3); doRpl("read full R9", 5);
    doRpl("read short R9", 3);
    doRpl("read truncated R9", 9);
    doRpl("read count zero R11", 0);
    doRpl("read count 21 R11", 21);
    doReq("i2c read mot len0 R2", 4'h5, 20'h00050, 0, 4);
    fillReply(4); doRpl("read len0 R9", 1);
    doReq("read len19 R3", 4'h9, 20'hFFFFF, 19, 6);
    fillReply(5); doRpl("read max R9", 20);
    doReq("read len20 R5", 4'h9, 20'h00001, 20, 8);

    // invalid commands
    doReq("cmd 3 R6", 4'h3, 20'h12121, 2, 1);
    doReq("cmd A R6", 4'hA, 20'h34343, 2, 1);
    doReq("cmd F R6", 4'hF, 20'h56565, 0, 1);
    fillReply(6); doRpl("reply after invalid R11", 2);

    finishRun();
  end
endmodule